// File: doc/BRIEF.md
# Shared Assignable Prescaler Divider

This block holds one 8-bit binary divider that can serve either a timer, where it slows the timer's count rate, or a watchdog, where it stretches the watchdog's timeout, but never both at once. A single owner-select input decides which side holds the divider, and a 3-bit ratio input chooses the division. The side that does not hold the divider receives its own tick undivided.

Each side has a clear strobe: a write to the timer count register on the timer side, and the watchdog clear on the watchdog side. A strobe resets the divider only when its side holds it. The divider count itself is hidden. Nothing can read it or load it. Moving ownership from one side to the other also resets the count, so a partial period never passes to the new owner. Both outputs are one-cycle pulses, registered, and appear in the cycle after the tick that produced them.

Top module: `psc_shared_div`

## Requirements
- R1: While reset is held, and in the two cycles after it is released, `tmr_inc` and `wdt_cnt` are 0. After reset the timer owns the divider (`own_wdt` = 0 is the stored owner) and the hidden count is 0.
- R2: With `own_wdt` = 0 and ratio value n, `tmr_inc` pulses once for every 2^(n+1) accepted `tmr_tick` cycles. The pulse is one cycle wide and appears in the cycle after the tick that completes the period.
- R3: With `own_wdt` = 1 and ratio value n from 1 to 7, `wdt_cnt` pulses once for every 2^n accepted `wdt_tick` cycles. With n = 0, every accepted `wdt_tick` gives a `wdt_cnt` pulse in the next cycle.
- R4: The side that does not own the divider sees its tick passed straight through: the output equals its tick input delayed by exactly one cycle, whatever clear strobes are active.
- R5: While the timer owns the divider, `tmr_wr` resets the count to 0. A `tmr_tick` in the same cycle is discarded and produces no pulse.
- R6: While the watchdog owns the divider, `wdt_clr` resets the count to 0. A `wdt_tick` in the same cycle is discarded and produces no pulse.
- R7: The clear strobe of the side that does not own the divider has no effect on the count.
- R8: A cycle in which `own_wdt` differs from the stored owner resets the count and discards the new owner's tick in that cycle. The non-owner tick in that cycle still passes through.
- R9: Changing `ratio` without changing the owner does not reset the count. The new value selects the divider tap from the next tick on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| own_wdt | input | 1 | Owner select: 0 gives the divider to the timer, 1 to the watchdog |
| ratio | input | 3 | Division select n |
| tmr_tick | input | 1 | Timer tick, one cycle per event |
| wdt_tick | input | 1 | Watchdog tick, one cycle per event |
| tmr_wr | input | 1 | Timer count register write strobe |
| wdt_clr | input | 1 | Watchdog clear strobe |
| tmr_inc | output | 1 | Timer increment pulse |
| wdt_cnt | output | 1 | Watchdog count pulse |

## Verification
Every output pulse, whether divided or passed through, is due exactly one cycle after the input cycle that caused it. The bench therefore drives each cycle's inputs on the falling edge and compares both outputs on the next falling edge, against a bench model that is stepped once per cycle. Clears, owner changes and ratio changes act in the cycle they are presented. Their effect shows up as a missing or shifted pulse on that same one-cycle schedule. After reset is released, the bench waits out the two synchronizer cycles before it applies the first stimulus.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic {
    OWNER_TMR = 1'b0,
    OWNER_WDT = 1'b1
  } owner_e;
endpackage

// File: rtl/psc_rst_sync.sv
module psc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/psc_count.sv
module psc_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         srst_n,
  input  logic         en,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cnt <= '0;
    else         cnt <= cnt_d;
  end
endmodule

// File: rtl/psc_tap.sv
module psc_tap #(
  parameter int W     = 8,
  parameter int SEL_W = 3
) (
  input  logic [W-1:0]     cnt,
  input  logic [SEL_W-1:0] ratio,
  input  logic             own_wdt,
  input  logic             en,
  input  logic             clr,
  output logic             div_pulse
);
  logic [W-1:0]     carry;
  logic [SEL_W-1:0] idx;
  logic             bypass;
  logic             hit;

  // carry[i] is set when the next increment clears bit i (falling edge)
  assign carry[0] = cnt[0];
  for (genvar i = 1; i < W; i++) begin : g_carry
    assign carry[i] = carry[i-1] & cnt[i];
  end

  always_comb begin
    bypass = own_wdt && (ratio == '0);
    idx    = own_wdt ? (ratio - SEL_W'(1)) : ratio;
    hit    = bypass | carry[idx];
    div_pulse = en & ~clr & hit;
  end
endmodule

// File: rtl/psc_route.sv
module psc_route (
  input  logic clk,
  input  logic srst_n,
  input  logic own_wdt,
  input  logic tmr_tick,
  input  logic wdt_tick,
  input  logic div_pulse,
  output logic tmr_inc,
  output logic wdt_cnt
);
  logic tmr_d, wdt_d;

  always_comb begin
    tmr_d = own_wdt ? tmr_tick  : div_pulse;
    wdt_d = own_wdt ? div_pulse : wdt_tick;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      tmr_inc <= 1'b0;
      wdt_cnt <= 1'b0;
    end else begin
      tmr_inc <= tmr_d;
      wdt_cnt <= wdt_d;
    end
  end
endmodule

// File: rtl/psc_shared_div.sv
module psc_shared_div #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             own_wdt,
  input  logic [SEL_W-1:0] ratio,
  input  logic             tmr_tick,
  input  logic             wdt_tick,
  input  logic             tmr_wr,
  input  logic             wdt_clr,
  output logic             tmr_inc,
  output logic             wdt_cnt
);
  import psc_pkg::*;

  localparam int TAPS = 1 << SEL_W;
  initial begin
    if (TAPS != CNT_W) $error("ratio field must address every divider bit");
  end

  logic         srst_n;
  owner_e       owner_q, owner_d;
  logic         swap, clr, en, div_pulse;
  logic [CNT_W-1:0] cnt;

  psc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  always_comb begin
    owner_d = own_wdt ? OWNER_WDT : OWNER_TMR;
    swap    = (owner_d != owner_q);
    clr     = swap | (own_wdt ? wdt_clr : tmr_wr);
    en      = own_wdt ? wdt_tick : tmr_tick;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) owner_q <= OWNER_TMR;
    else         owner_q <= owner_d;
  end

  psc_count #(.W(CNT_W)) u_cnt (
    .clk(clk), .srst_n(srst_n), .en(en), .clr(clr), .cnt(cnt)
  );

  psc_tap #(.W(CNT_W), .SEL_W(SEL_W)) u_tap (
    .cnt(cnt), .ratio(ratio), .own_wdt(own_wdt), .en(en), .clr(clr),
    .div_pulse(div_pulse)
  );

  psc_route u_route (
    .clk(clk), .srst_n(srst_n), .own_wdt(own_wdt), .tmr_tick(tmr_tick),
    .wdt_tick(wdt_tick), .div_pulse(div_pulse), .tmr_inc(tmr_inc),
    .wdt_cnt(wdt_cnt)
  );
endmodule

// File: rtl/psc_shared_div_chk.sv
module psc_shared_div_chk #(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             srst_n,
  input logic             own_wdt,
  input logic [SEL_W-1:0] ratio,
  input logic             tmr_tick,
  input logic             wdt_tick,
  input logic             tmr_wr,
  input logic             wdt_clr,
  input logic             tmr_inc,
  input logic             wdt_cnt
);
  logic live_q, live2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q  <= 1'b0;
      live2_q <= 1'b0;
    end else begin
      live_q  <= srst_n;
      live2_q <= live_q;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !srst_n |-> (!tmr_inc && !wdt_cnt));

  // R2
  tmr_cause_chk: assert property (@(posedge clk) disable iff (!live_q)
    tmr_inc |-> $past(tmr_tick));

  // R3
  wdt_cause_chk: assert property (@(posedge clk) disable iff (!live_q)
    wdt_cnt |-> $past(wdt_tick));

  // R4
  wdt_pass_chk: assert property (@(posedge clk) disable iff (!live_q)
    $past(!own_wdt) |-> (wdt_cnt == $past(wdt_tick)));

  // R4
  tmr_pass_chk: assert property (@(posedge clk) disable iff (!live_q)
    $past(own_wdt) |-> (tmr_inc == $past(tmr_tick)));

  // R5
  tmr_clr_drop_chk: assert property (@(posedge clk) disable iff (!live_q)
    $past(!own_wdt && tmr_tick && tmr_wr) |-> !tmr_inc);

  // R6
  wdt_clr_drop_chk: assert property (@(posedge clk) disable iff (!live_q)
    $past(own_wdt && wdt_tick && wdt_clr) |-> !wdt_cnt);

  // R3
  wdt_div1_chk: assert property (@(posedge clk) disable iff (!live2_q)
    ($past(own_wdt) && $past(own_wdt, 2) && $past(ratio) == '0 &&
     $past(wdt_tick) && !$past(wdt_clr)) |-> wdt_cnt);
endmodule

bind psc_shared_div psc_shared_div_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .srst_n(srst_n), .own_wdt(own_wdt),
  .ratio(ratio), .tmr_tick(tmr_tick), .wdt_tick(wdt_tick),
  .tmr_wr(tmr_wr), .wdt_clr(wdt_clr), .tmr_inc(tmr_inc), .wdt_cnt(wdt_cnt)
);

// File: tb/tb_psc_shared_div.sv
module tb_psc_shared_div;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic       own_wdt, tmr_tick, wdt_tick, tmr_wr, wdt_clr;
  logic [2:0] ratio;
  logic       tmr_inc, wdt_cnt;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model state
  logic [7:0] m_cnt;
  logic       m_own;

  psc_shared_div dut (
    .clk(clk), .rst_n(rst_n), .own_wdt(own_wdt), .ratio(ratio),
    .tmr_tick(tmr_tick), .wdt_tick(wdt_tick), .tmr_wr(tmr_wr),
    .wdt_clr(wdt_clr), .tmr_inc(tmr_inc), .wdt_cnt(wdt_cnt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic wraps(input logic [7:0] c, input int k);
    logic [7:0] mask = 8'((16'd1 << (k + 1)) - 16'd1);
    return (c & mask) == mask;
  endfunction

  task automatic check(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic cyc(input string tag, input logic o, input logic [2:0] r,
                     input logic tt, input logic wt, input logic tw, input logic wc);
    logic clr, en, et, ew;
    own_wdt = o; ratio = r; tmr_tick = tt; wdt_tick = wt; tmr_wr = tw; wdt_clr = wc;
    clr = (o != m_own) | (o ? wc : tw);
    en  = o ? wt : tt;
    et  = o ? tt : (en & ~clr & wraps(m_cnt, int'(r)));
    if (!o)            ew = wt;
    else if (r == 3'd0) ew = en & ~clr;
    else               ew = en & ~clr & wraps(m_cnt, int'(r) - 1);
    @(negedge clk);
    check(tag, "tmr_inc", tmr_inc, et);
    check(tag, "wdt_cnt", wdt_cnt, ew);
    if (clr)     m_cnt = '0;
    else if (en) m_cnt = m_cnt + 8'd1;
    m_own = o;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed;
    logic o;
    logic [2:0] r;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    rst_n = 1'b0; own_wdt = 0; ratio = 0;
    tmr_tick = 0; wdt_tick = 0; tmr_wr = 0; wdt_clr = 0;
    m_cnt = '0; m_own = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "tmr_inc", tmr_inc, 1'b0);
    check("R1", "wdt_cnt", wdt_cnt, 1'b0);
    rst_n = 1'b1;
    repeat (2) begin
      @(negedge clk);
      check("R1 release", "tmr_inc", tmr_inc, 1'b0);
      check("R1 release", "wdt_cnt", wdt_cnt, 1'b0);
    end

    // R2: every timer ratio, continuous and gapped ticks
    for (int n = 0; n < 8; n++)
      for (int i = 0; i < (2 << n) + 3; i++) cyc("R2", 0, 3'(n), 1'b1, i[0], 0, 0);
    for (int i = 0; i < 40; i++) cyc("R2 gapped", 0, 3'd2, i[1], 1'b1, 0, 0);

    // R5: write clear mid-count and colliding with tick
    for (int i = 0; i < 20; i++) cyc("R5", 0, 3'd2, 1'b1, 0, (i == 5) || (i == 14), 0);
    // R7: watchdog clear ignored while timer owns
    for (int i = 0; i < 20; i++) cyc("R7 tmr", 0, 3'd2, 1'b1, 0, 0, i[0]);

    // R8: hand over to watchdog, R3 every watchdog ratio
    cyc("R8", 1, 3'd0, 1'b1, 1'b1, 0, 0);
    for (int n = 0; n < 8; n++)
      for (int i = 0; i < (1 << n) + 3; i++) cyc("R3", 1, 3'(n), i[0], 1'b1, 0, 0);
    // R4: timer passthrough with timer writes while watchdog owns
    for (int i = 0; i < 12; i++) cyc("R4", 1, 3'd3, i[0], 1'b1, 1'b1, 0);
    // R6: watchdog clear, R7 timer write ignored
    for (int i = 0; i < 20; i++) cyc("R6", 1, 3'd3, 0, 1'b1, 0, i == 6);
    for (int i = 0; i < 20; i++) cyc("R7 wdt", 1, 3'd3, 0, 1'b1, i[0], 0);
    // R9: ratio change without clear
    for (int i = 0; i < 30; i++) cyc("R9", 1, (i < 5) ? 3'd4 : 3'd2, 0, 1'b1, 0, 0);
    // R8: back to timer with a partial count
    for (int i = 0; i < 3; i++) cyc("R8 partial", 1, 3'd3, 0, 1'b1, 0, 0);
    for (int i = 0; i < 10; i++) cyc("R8 back", 0, 3'd1, 1'b1, 1'b1, 0, 0);

    // random mix
    o = 0; r = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(99) < 3)  o = ~o;
      if ($urandom_range(99) < 4)  r = 3'($urandom_range(7));
      cyc(o ? "R3/R4 random" : "R2/R4 random", o, r,
          $urandom_range(99) < 70, $urandom_range(99) < 60,
          $urandom_range(99) < 3,  $urandom_range(99) < 3);
    end
    finish_run();
  end
endmodule